// File: doc/BRIEF.md
# Linked-Descriptor Single-Channel DMA Engine

This block is one DMA channel that moves a run of elements between a fixed device address and a range of memory. The element size is 1, 2 or 4 bytes. The work is described by a four-word descriptor: a device address, a memory address, a size word and a link word. Software writes the descriptor into four channel registers through a small register port.

The channel has two ways to run:
- **Single-descriptor mode** executes the descriptor that is already held in the registers.
- **Chained mode** treats the link register as a pointer. It fetches 16-byte descriptors from memory, one after another, until it reaches a descriptor that marks the end of the chain.

Each element is moved with one read and then one write on a plain request/ready memory master port. A two-bit state output shows whether the channel is idle, fetching a descriptor, waiting between accesses, or moving data. A one-cycle pulse reports the completion of a descriptor that asked for an interrupt. A separate one-cycle pulse reports a fault.

Top module: `dma_chan_engine`

## Requirements
- R1: The register port holds four 32-bit registers, selected by `reg_idx`: 0 = device address, 1 = memory address, 2 = size, 3 = link. `reg_rdata` returns the selected register. A write through the port takes effect only while the channel is idle; a write made while the channel is busy leaves the register unchanged.
- R2: Mode 2'b10 is single-descriptor mode. A rising change from disabled to this mode while idle starts the register descriptor once, and the channel then returns to idle. The follow bit of the link word is ignored in this mode.
- R3: Mode 2'b01 is chained mode.
  - The channel reads four words into registers 0..3, in that order, at the link pointer with its two low bits cleared, using offsets +0, +4, +8 and +12.
  - After a descriptor finishes, link bit 1 = 1 fetches the next descriptor; link bit 1 = 0 ends the chain.
- R4: Each element is one read followed by one write that carries the data just read.
  - Direction 1 reads at the memory address and writes to the device address.
  - Direction 0 reads the device address and writes at the memory address.
- R5: The size word bits [13:12] give the element width: 3 = 1 byte, 2 = 2 bytes, 0 = 4 bytes. The memory address register advances by that width after each element. The device address stays fixed.
- R6: The element count is size bits [10:0] for the 4-byte width and bits [9:0] for the narrower widths. A count of zero finishes the descriptor with no data access.
- R7: `state_o` reports the channel state:
  - 0 when idle;
  - 1 while a descriptor word is requested;
  - 3 while a data access is requested;
  - 2 between accesses.
  A memory request is raised only in states 1 and 3.
- R8: When a descriptor whose link bit 0 is 1 finishes, `irq_o` pulses for one cycle. In that cycle the state is idle or descriptor fetch.
- R9: A fault stops the channel. A fault is either a width code of 1 or an access that completes with `mem_err` high. On a fault, `err_o` pulses for one cycle with the state idle, no further access is made, and no interrupt is raised.
- R10: Mode 2'b00 or 2'b11 means disabled. Disabling a running channel stops it at the next element boundary, so a started element always finishes its write. The channel then goes idle without an interrupt. Entering 2'b11 from 2'b00 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | 01 chained, 10 single descriptor, others disabled |
| dir_i | input | 1 | 1 memory to device, 0 device to memory (sampled at start) |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 32 | Access byte address |
| mem_we | output | 1 | Access is a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ready |
| mem_ready | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Completing access failed |
| state_o | output | 2 | Channel state code |
| irq_o | output | 1 | Descriptor-complete interrupt pulse |
| err_o | output | 1 | Fault pulse |

## Verification
The single-descriptor function is swept over every supported width, both directions, counts of zero, one and three, and two memory latencies. This separates address stepping per width, the ordering of reads and writes in each direction, and the zero-count shortcut. The interrupt code also rotates through all four link codes, which shows that bit 0 alone drives the pulse and that the follow bit is ignored in this mode.

A four-descriptor chain mixes widths, includes a zero-count descriptor, and starts from an unaligned pointer. It checks the fetch order, the pointer masking and the interrupt count.

Separate runs cover the remaining behaviour:
- the wide count with a stray bit set;
- a bad width code in both modes;
- a bus error in the middle of a transfer;
- a disable in the middle of a transfer, combined with a register write made while busy;
- the reserved mode value.

// File: rtl/dce_pkg.sv
package dce_pkg;

  localparam int DCE_WORD_W    = 32;
  localparam int DCE_CNT_W     = 11;
  localparam int DCE_WIDTH_LSB = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RD,
    ST_HOLD,
    ST_WR,
    ST_NEXT
  } dce_state_e;

  localparam logic [1:0] RPT_IDLE = 2'd0;
  localparam logic [1:0] RPT_DESC = 2'd1;
  localparam logic [1:0] RPT_WAIT = 2'd2;
  localparam logic [1:0] RPT_XFER = 2'd3;

  localparam logic [1:0] MODE_CHAIN  = 2'b01;
  localparam logic [1:0] MODE_SINGLE = 2'b10;

  function automatic logic [1:0] width_code(input logic [DCE_WORD_W-1:0] size_w);
    return size_w[DCE_WIDTH_LSB +: 2];
  endfunction

  function automatic logic width_ok(input logic [DCE_WORD_W-1:0] size_w);
    return width_code(size_w) != 2'd1;
  endfunction

  function automatic logic [2:0] width_bytes(input logic [DCE_WORD_W-1:0] size_w);
    case (width_code(size_w))
      2'd3:    return 3'd1;
      2'd2:    return 3'd2;
      2'd0:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [DCE_CNT_W-1:0] elem_count(input logic [DCE_WORD_W-1:0] size_w);
    if (width_code(size_w) == 2'd0)
      return size_w[DCE_CNT_W-1:0];
    else
      return {1'b0, size_w[DCE_CNT_W-2:0]};
  endfunction

  function automatic logic [1:0] state_report(input dce_state_e s);
    case (s)
      ST_IDLE:         return RPT_IDLE;
      ST_FETCH:        return RPT_DESC;
      ST_RD, ST_WR:    return RPT_XFER;
      default:         return RPT_WAIT;
    endcase
  endfunction

  function automatic logic mode_enabled(input logic [1:0] m);
    return (m == MODE_CHAIN) || (m == MODE_SINGLE);
  endfunction

endpackage

// File: rtl/dce_desc_regs.sv
module dce_desc_regs #(
  parameter int W     = 32,
  parameter int NREG  = 4,
  parameter int STEPI = 1,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [W-1:0]  host_data,
  input  logic          load_we,
  input  logic [IW-1:0] load_idx,
  input  logic [W-1:0]  load_data,
  input  logic          step_en,
  input  logic [2:0]    step_bytes,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  q_flat [NREG]
);

  logic [W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= '0;
      else if (host_we && host_idx == IW'(i))
        q[i] <= host_data;
      else if (load_we && load_idx == IW'(i))
        q[i] <= load_data;
      else if (i == STEPI && step_en)
        q[i] <= q[i] + W'(step_bytes);
    end
    assign q_flat[i] = q[i];
  end

  assign rd_data = q[rd_idx];

endmodule

// File: rtl/dce_ctrl.sv
module dce_ctrl
  import dce_pkg::*;
#(
  parameter int W    = 32,
  parameter int CW   = 11,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          dir_i,
  input  logic [W-1:0]  r_dev,
  input  logic [W-1:0]  r_mem,
  input  logic [W-1:0]  r_size,
  input  logic [W-1:0]  r_next,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          load_we,
  output logic [IW-1:0] load_idx,
  output logic          step_en,
  output logic [2:0]    step_bytes,
  output logic          idle_o,
  output logic [1:0]    state_o,
  output logic          irq_o,
  output logic          err_o
);

  dce_state_e    st;
  logic [IW-1:0] fidx;
  logic [W-1:0]  fptr;
  logic [CW-1:0] rem;
  logic [W-1:0]  data_q;
  logic          dir_q, sg_q, en_q, irq_q, err_q;

  // named internal events
  logic en_now, start_ev, acc_done, acc_ok, bus_fault, last_word, desc_done;
  logic [W-1:0] link_ptr;

  assign en_now    = mode_enabled(mode_i);
  assign start_ev  = (st == ST_IDLE) && en_now && !en_q;
  assign acc_done  = mem_req && mem_ready;
  assign acc_ok    = acc_done && !mem_err;
  assign bus_fault = acc_done && mem_err;
  assign last_word = (fidx == IW'(NREG - 1));
  assign desc_done = (st == ST_NEXT) && en_now && (rem == '0);
  assign link_ptr  = {r_next[W-1:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      fidx   <= '0;
      fptr   <= '0;
      rem    <= '0;
      data_q <= '0;
      dir_q  <= 1'b0;
      sg_q   <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      en_q  <= en_now;
      irq_q <= 1'b0;
      err_q <= 1'b0;
      case (st)
        ST_IDLE: if (start_ev) begin
          dir_q <= dir_i;
          if (mode_i == MODE_CHAIN) begin
            sg_q <= 1'b1;
            fidx <= '0;
            fptr <= link_ptr;
            st   <= ST_FETCH;
          end else begin
            sg_q <= 1'b0;
            if (width_ok(r_size)) begin
              rem <= elem_count(r_size);
              st  <= ST_NEXT;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (bus_fault) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (acc_ok) begin
            if (last_word) begin
              if (width_ok(r_size)) begin
                rem <= elem_count(r_size);
                st  <= ST_NEXT;
              end else begin
                err_q <= 1'b1;
                st    <= ST_IDLE;
              end
            end else begin
              fidx <= fidx + 1'b1;
            end
          end
        end
        ST_NEXT: begin
          if (!en_now) begin
            st <= ST_IDLE;
          end else if (rem == '0) begin
            irq_q <= r_next[0];
            if (sg_q && r_next[1]) begin
              fidx <= '0;
              fptr <= link_ptr;
              st   <= ST_FETCH;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            st <= ST_RD;
          end
        end
        ST_RD: begin
          if (bus_fault) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (acc_ok) begin
            data_q <= mem_rdata;
            st     <= ST_HOLD;
          end
        end
        ST_HOLD: st <= ST_WR;
        ST_WR: begin
          if (bus_fault) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (acc_ok) begin
            rem <= rem - 1'b1;
            st  <= ST_NEXT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = (st == ST_FETCH) || (st == ST_RD) || (st == ST_WR);
    mem_we   = (st == ST_WR);
    case (st)
      ST_FETCH: mem_addr = fptr + W'({fidx, 2'b00});
      ST_RD:    mem_addr = dir_q ? r_mem : r_dev;
      ST_WR:    mem_addr = dir_q ? r_dev : r_mem;
      default:  mem_addr = '0;
    endcase
  end

  assign mem_wdata  = data_q;
  assign load_we    = (st == ST_FETCH) && acc_ok;
  assign load_idx   = fidx;
  assign step_en    = (st == ST_WR) && acc_ok;
  assign step_bytes = width_bytes(r_size);
  assign idle_o     = (st == ST_IDLE);
  assign state_o    = state_report(st);
  assign irq_o      = irq_q;
  assign err_o      = err_q;

  assert_idle_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == RPT_IDLE) |-> !mem_req);
  assert_req_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (state_o == RPT_DESC || state_o == RPT_XFER));
  assert_fetch_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && state_o == RPT_DESC) |-> !mem_we);
  assert_write_follows_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(state_o) == RPT_WAIT);
  assert_done_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dce_pkg::*;
#(
  parameter int W    = DCE_WORD_W,
  parameter int CW   = DCE_CNT_W,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          dir_i,
  input  logic          reg_wr,
  input  logic [IW-1:0] reg_idx,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic [1:0]    state_o,
  output logic          irq_o,
  output logic          err_o
);

  logic [W-1:0]  q [NREG];
  logic          load_we, step_en, idle, host_we;
  logic [IW-1:0] load_idx;
  logic [2:0]    step_bytes;

  assign host_we = reg_wr && idle;

  dce_desc_regs #(.W(W), .NREG(NREG), .STEPI(1)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_idx   (reg_idx),
    .host_data  (reg_wdata),
    .load_we    (load_we),
    .load_idx   (load_idx),
    .load_data  (mem_rdata),
    .step_en    (step_en),
    .step_bytes (step_bytes),
    .rd_idx     (reg_idx),
    .rd_data    (reg_rdata),
    .q_flat     (q)
  );

  dce_ctrl #(.W(W), .CW(CW), .NREG(NREG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .dir_i      (dir_i),
    .r_dev      (q[0]),
    .r_mem      (q[1]),
    .r_size     (q[2]),
    .r_next     (q[3]),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ready  (mem_ready),
    .mem_err    (mem_err),
    .load_we    (load_we),
    .load_idx   (load_idx),
    .step_en    (step_en),
    .step_bytes (step_bytes),
    .idle_o     (idle),
    .state_o    (state_o),
    .irq_o      (irq_o),
    .err_o      (err_o)
  );

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_o, err_o}));
  assert_irq_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (state_o == RPT_IDLE || state_o == RPT_DESC));
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> state_o == RPT_IDLE);
  assert_busy_write_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && state_o != RPT_IDLE) |-> !host_we);

endmodule

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;

  localparam logic [31:0] DEV   = 32'h0000_8000;
  localparam logic [31:0] DPAT  = 32'hDE00_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        dir_i = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0, mem_err = 1'b0;
  logic [1:0]  state_o;
  logic        irq_o, err_o;

  always #2.5 clk = ~clk;

  dma_chan_engine uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
    .state_o(state_o), .irq_o(irq_o), .err_o(err_o)
  );

  int n_checks = 0, n_fail = 0;
  logic [31:0] wr_a [64];
  logic [31:0] wr_d [64];
  logic [31:0] rd_a [64];
  logic [31:0] dtab [16];
  int n_wr, n_rd, n_irq, n_err, dev_reads, acc_total, err_at, lat, wait_cnt, bad_state;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return 32'h5A00_0000 ^ a;
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clr_logs();
    n_wr = 0; n_rd = 0; n_irq = 0; n_err = 0; dev_reads = 0;
    acc_total = 0; err_at = -1; bad_state = 0;
  endtask

  // memory / device model and output monitor, all at the falling edge
  initial begin
    wait_cnt = 0; lat = 0;
    clr_logs();
    forever begin
      @(negedge clk);
      if (irq_o) n_irq++;
      if (err_o) n_err++;
      if (mem_req && !(state_o == 2'd1 || state_o == 2'd3)) bad_state++;
      if (mem_req && ((state_o == 2'd1) != (mem_addr[31:6] == 26'h10))) bad_state++;
      if (mem_req && state_o == 2'd1 && mem_we) bad_state++;
      if (!mem_req && state_o == 2'd0 && (irq_o && err_o)) bad_state++;
      if (mem_req) begin
        if (wait_cnt >= lat) begin
          mem_ready = 1'b1;
          mem_err   = (acc_total == err_at);
          if (mem_we) begin
            if (n_wr < 64) begin wr_a[n_wr] = mem_addr; wr_d[n_wr] = mem_wdata; end
            n_wr++;
          end else begin
            if (n_rd < 64) rd_a[n_rd] = mem_addr;
            n_rd++;
            if (mem_addr == DEV) begin
              mem_rdata = DPAT | 32'(dev_reads);
              dev_reads++;
            end else if (mem_addr[31:6] == 26'h10) begin
              mem_rdata = dtab[mem_addr[5:2]];
            end else begin
              mem_rdata = mem_word(mem_addr);
            end
          end
          acc_total++;
          wait_cnt = 0;
        end else begin
          mem_ready = 1'b0; mem_err = 1'b0; wait_cnt++;
        end
      end else begin
        mem_ready = 1'b0; mem_err = 1'b0; wait_cnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  task automatic wreg(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    int guard = 0;
    repeat (3) @(negedge clk);
    while (state_o != 2'd0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic run(input logic [1:0] m);
    @(negedge clk);
    mode_i = m;
    wait_done();
    @(negedge clk);
    mode_i = 2'b00;
    @(negedge clk);
  endtask

  logic [31:0] exp_rd [64];
  int k;
  task automatic push_rd(input logic [31:0] a);
    exp_rd[k] = a; k++;
  endtask

  initial begin
    logic [31:0] v;
    int counts [3] = '{0, 1, 3};
    int runno = 0;

    repeat (4) @(negedge clk);
    // reset state
    check_eq("R7", "reset state", {30'd0, state_o}, 32'd0);
    check_eq("R8", "reset irq/err/req", {29'd0, irq_o, err_o, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rdreg(2'd3, v);
    check_eq("R1", "reset link register", v, 32'd0);

    // R1: register write and readback
    wreg(2'd0, 32'h1234_5678);
    rdreg(2'd0, v);
    check_eq("R1", "dev register readback", v, 32'h1234_5678);

    // single-descriptor sweep: width x direction x count x latency
    for (int wi = 0; wi < 3; wi++) begin
      for (int d = 0; d < 2; d++) begin
        for (int ci = 0; ci < 3; ci++) begin
          for (int li = 0; li < 2; li++) begin
            logic [1:0]  wc;
            int          w, cnt, mism;
            logic [31:0] base, code;
            wc   = (wi == 0) ? 2'd3 : ((wi == 1) ? 2'd2 : 2'd0);
            w    = (wi == 0) ? 1 : ((wi == 1) ? 2 : 4);
            cnt  = counts[ci];
            base = 32'h1000 + 32'(runno) * 32'h40 + 32'((w == 1) ? 3 : ((w == 2) ? 2 : 0));
            code = 32'(runno % 4);
            wreg(2'd0, DEV);
            wreg(2'd1, base);
            wreg(2'd2, (32'(wc) << 12) | 32'(cnt));
            wreg(2'd3, 32'h0000_0440 | code);
            dir_i = d[0];
            lat = li * 2;
            clr_logs();
            run(2'b10);
            check_eq("R2", "single-mode write count", 32'(n_wr), 32'(cnt));
            check_eq("R6", "single-mode read count", 32'(n_rd), 32'(cnt));
            mism = 0;
            for (int i = 0; i < cnt; i++) begin
              logic [31:0] ea, ed, er;
              if (d == 1) begin
                er = base + 32'(i * w); ea = DEV; ed = mem_word(er);
              end else begin
                er = DEV; ea = base + 32'(i * w); ed = DPAT | 32'(i);
              end
              if (rd_a[i] !== er || wr_a[i] !== ea || wr_d[i] !== ed) mism++;
            end
            check_eq("R4", "element address/data mismatches", 32'(mism), 32'd0);
            rdreg(2'd1, v);
            check_eq("R5", "memory address after run", v, base + 32'(cnt * w));
            rdreg(2'd0, v);
            check_eq("R5", "device address unchanged", v, DEV);
            check_eq("R8", "irq pulses vs link bit0", 32'(n_irq), {31'd0, code[0]});
            check_eq("R7", "state/request coherence", 32'(bad_state), 32'd0);
            runno++;
          end
        end
      end
    end

    // R6: wide count uses bits [10:0]; narrow ignores bit 10
    lat = 0; dir_i = 1'b1;
    wreg(2'd1, 32'h3000);
    wreg(2'd2, (32'd0 << 12) | 32'h401);
    wreg(2'd3, 32'h0);
    clr_logs();
    run(2'b10);
    check_eq("R6", "4-byte count 0x401", 32'(n_wr), 32'h401);
    wreg(2'd1, 32'h3000);
    wreg(2'd2, (32'd3 << 12) | 32'h402);
    clr_logs();
    run(2'b10);
    check_eq("R6", "1-byte count ignores bit10", 32'(n_wr), 32'd2);

    // R3: four-descriptor chain, unaligned start pointer
    dtab[0]  = DEV; dtab[1]  = 32'h2000; dtab[2]  = (32'd2 << 12) | 32'd2; dtab[3]  = 32'h412;
    dtab[4]  = DEV; dtab[5]  = 32'h2100; dtab[6]  = (32'd0 << 12) | 32'd0; dtab[7]  = 32'h423;
    dtab[8]  = DEV; dtab[9]  = 32'h2200; dtab[10] = (32'd0 << 12) | 32'd1; dtab[11] = 32'h432;
    dtab[12] = DEV; dtab[13] = 32'h2301; dtab[14] = (32'd3 << 12) | 32'd3; dtab[15] = 32'h441;
    wreg(2'd3, 32'h403);
    dir_i = 1'b1; lat = 1;
    clr_logs();
    run(2'b01);
    k = 0;
    for (int i = 0; i < 4; i++) push_rd(32'h400 + 32'(4 * i));
    push_rd(32'h2000); push_rd(32'h2002);
    for (int i = 0; i < 4; i++) push_rd(32'h410 + 32'(4 * i));
    for (int i = 0; i < 4; i++) push_rd(32'h420 + 32'(4 * i));
    push_rd(32'h2200);
    for (int i = 0; i < 4; i++) push_rd(32'h430 + 32'(4 * i));
    push_rd(32'h2301); push_rd(32'h2302); push_rd(32'h2303);
    check_eq("R3", "chain read count", 32'(n_rd), 32'(k));
    begin
      int mism = 0;
      for (int i = 0; i < k; i++) if (rd_a[i] !== exp_rd[i]) mism++;
      check_eq("R3", "chain read order mismatches", 32'(mism), 32'd0);
      mism = 0;
      for (int i = 0; i < 6; i++)
        if (wr_a[i] !== DEV || wr_d[i] !== mem_word(rd_a[(i < 2) ? 4 + i : ((i == 2) ? 14 : 16 + i)]))
          mism++;
      check_eq("R4", "chain write mismatches", 32'(mism), 32'd0);
    end
    check_eq("R3", "chain write count", 32'(n_wr), 32'd6);
    check_eq("R8", "chain irq pulses", 32'(n_irq), 32'd2);
    rdreg(2'd3, v);
    check_eq("R3", "link register after chain", v, 32'h441);
    rdreg(2'd1, v);
    check_eq("R5", "memory address after chain", v, 32'h2304);
    check_eq("R7", "chain state coherence", 32'(bad_state), 32'd0);

    // R9: bad width code in single mode
    lat = 0;
    wreg(2'd2, (32'd1 << 12) | 32'd2);
    wreg(2'd3, 32'h1);
    clr_logs();
    run(2'b10);
    check_eq("R9", "bad width single: err pulses", 32'(n_err), 32'd1);
    check_eq("R9", "bad width single: accesses", 32'(acc_total), 32'd0);
    check_eq("R9", "bad width single: irq", 32'(n_irq), 32'd0);

    // R9: bad width code in a fetched descriptor
    dtab[2] = (32'd1 << 12) | 32'd2;
    wreg(2'd3, 32'h400);
    clr_logs();
    run(2'b01);
    check_eq("R9", "bad width chain: reads", 32'(n_rd), 32'd4);
    check_eq("R9", "bad width chain: writes", 32'(n_wr), 32'd0);
    check_eq("R9", "bad width chain: err pulses", 32'(n_err), 32'd1);

    // R9: bus error on third access (read of element 1)
    wreg(2'd0, DEV);
    wreg(2'd1, 32'h5000);
    wreg(2'd2, (32'd0 << 12) | 32'd4);
    wreg(2'd3, 32'h1);
    dir_i = 1'b1;
    clr_logs();
    err_at = 2;
    run(2'b10);
    repeat (10) @(negedge clk);
    check_eq("R9", "bus error: total accesses", 32'(acc_total), 32'd3);
    check_eq("R9", "bus error: writes", 32'(n_wr), 32'd1);
    check_eq("R9", "bus error: err pulses", 32'(n_err), 32'd1);
    check_eq("R9", "bus error: irq", 32'(n_irq), 32'd0);
    check_eq("R9", "bus error: idle", {30'd0, state_o}, 32'd0);

    // R10 + R1: disable mid-run, with a register write while busy
    wreg(2'd0, DEV);
    wreg(2'd1, 32'h6000);
    wreg(2'd2, (32'd2 << 12) | 32'd20);
    wreg(2'd3, 32'h1);
    dir_i = 1'b1; lat = 2;
    clr_logs();
    @(negedge clk);
    mode_i = 2'b10;
    repeat (8) @(negedge clk);
    reg_wr = 1'b1; reg_idx = 2'd0; reg_wdata = 32'h0000_0BAD;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (10) @(negedge clk);
    mode_i = 2'b00;
    wait_done();
    repeat (2) @(negedge clk);
    check_eq("R10", "disable: reads equal writes", 32'(n_rd), 32'(n_wr));
    check_eq("R10", "disable: stopped early", 32'(n_wr > 0 && n_wr < 20), 32'd1);
    check_eq("R10", "disable: no irq", 32'(n_irq), 32'd0);
    check_eq("R10", "disable: no err", 32'(n_err), 32'd0);
    rdreg(2'd1, v);
    check_eq("R5", "disable: memory address", v, 32'h6000 + 32'(n_wr * 2));
    rdreg(2'd0, v);
    check_eq("R1", "busy write ignored", v, DEV);
    begin
      int mism = 0;
      for (int i = 0; i < n_wr; i++) if (wr_a[i] !== DEV) mism++;
      check_eq("R1", "device address during busy write", 32'(mism), 32'd0);
    end

    // R10: reserved mode 11 starts nothing
    lat = 0;
    clr_logs();
    @(negedge clk);
    mode_i = 2'b11;
    repeat (10) @(negedge clk);
    check_eq("R10", "mode 11 state", {30'd0, state_o}, 32'd0);
    check_eq("R10", "mode 11 accesses", 32'(acc_total), 32'd0);
    mode_i = 2'b00;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule